// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level radix page table held in memory. A translation miss starts it. It takes the first ten address bits as an index into a root table, which a base input locates. The entry found there gives the frame of a leaf table. The next ten bits index that leaf table. The low twelve bits are the page offset and pass through unchanged, so pages are 4 KB and each table holds 1024 four-byte entries.

Memory is read through a single request/response port. A request is held with valid/ready until it is accepted, and the response may come back after any number of cycles. Every entry has three parts:

- bit 0: present
- bit 1: write permission
- bits 31:12: physical page number

If an entry at either level is not present, the walk ends with a not-present fault. A write to a leaf without write permission ends with a protection fault. In both cases no translation is returned. The result is presented for one cycle. A new miss is taken only after the previous one has produced its result.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready is 1, mem_req_valid is 0 and res_valid is 0.
- R2: The first memory read of a walk goes to address {ptbr[31:12], vaddr[31:22], 2'b00}. The low twelve bits of ptbr have no effect.
- R3: When the root entry is present, the second read goes to {root entry[31:12], vaddr[21:12], 2'b00}.
- R4: A successful walk reports res_fault = 0 and res_paddr = {leaf[31:12], vaddr[11:0]}. res_writable equals leaf bit 1.
- R5: A memory request keeps mem_req_valid high and mem_req_addr stable until mem_req_ready is seen. The walker waits any number of cycles for mem_rsp_valid.
- R6: A root entry with bit 0 clear ends the walk after that single read, with res_fault = 1 (not present), res_paddr = 0 and res_writable = 0.
- R7: A leaf entry with bit 0 clear ends the walk with res_fault = 1, res_paddr = 0 and res_writable = 0.
- R8: A write to a present leaf whose bit 1 is clear gives res_fault = 2 (protection) and res_paddr = 0. A read of such a leaf succeeds. Bit 1 of the root entry has no effect.
- R9: req_ready is low from the cycle after a miss is accepted until the result is presented. Requests offered during that time are ignored.
- R10: Each accepted miss produces exactly one result, and res_valid is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 32 | Root table base address; only bits 31:12 are used |
| req_valid | input | 1 | Translation miss request |
| req_ready | output | 1 | Walker idle and able to take a miss |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 2 | 0 ok, 1 not present, 2 protection |
| res_paddr | output | 32 | Physical address, zero on a fault |
| res_writable | output | 1 | Leaf grants write permission |

## Verification
A corrupted walk state would show up within a single walk, in one of three ways:

- a wrong entry address on the memory port, compared read by read against the address the bench expects;
- a wrong number of reads;
- a fault code or physical address that differs from what the bench computes from the same hashed memory image.

A stuck or lost state would show up as a result that never arrives, or as req_ready staying low. A walk with random response latency would expose either within tens of cycles. Requests offered while busy with a different address would corrupt the latched address visibly, so the next result would carry the wrong offset or page.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W     = 32,
  parameter int L1_W     = 10,
  parameter int L2_W     = 10,
  parameter int PTE_BYTE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] ptbr,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            res_valid,
  output logic [1:0]      res_fault,
  output logic [VA_W-1:0] res_paddr,
  output logic            res_writable
);
  localparam int OFF_W = VA_W - L1_W - L2_W;
  localparam int PPN_W = VA_W - OFF_W;
  localparam logic [1:0] F_OK = 2'd0, F_NP = 2'd1, F_PROT = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2, S_DONE} st_t;

  st_t              st;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PPN_W-1:0] frame_q;
  logic [1:0]       fault_q;
  logic             wen_q;

  wire              ent_v  = mem_rsp_data[0];
  wire              ent_w  = mem_rsp_data[1];
  wire [PPN_W-1:0]  ent_pn = mem_rsp_data[VA_W-1 -: PPN_W];
  wire [L1_W-1:0]   idx1   = va_q[VA_W-1 -: L1_W];
  wire [L2_W-1:0]   idx2   = va_q[OFF_W +: L2_W];

  wire unused_ok = &{1'b0, mem_rsp_data[OFF_W-1:2], ptbr[OFF_W-1:0]};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD1) || (st == S_RD2);
  assign mem_req_addr  = (st == S_RD2) ? {frame_q, idx2, {PTE_BYTE{1'b0}}}
                                       : {ptbr[VA_W-1 -: PPN_W], idx1, {PTE_BYTE{1'b0}}};
  assign res_valid     = (st == S_DONE);
  assign res_fault     = fault_q;
  assign res_paddr     = (fault_q == F_OK) ? {frame_q, va_q[OFF_W-1:0]} : '0;
  assign res_writable  = wen_q && (fault_q == F_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      frame_q <= '0;
      fault_q <= F_OK;
      wen_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          st    <= S_RD1;
        end
        S_RD1: if (mem_req_ready) st <= S_WT1;
        S_WT1: if (mem_rsp_valid) begin
          frame_q <= ent_pn;
          if (!ent_v) begin
            fault_q <= F_NP;
            wen_q   <= 1'b0;
            st      <= S_DONE;
          end else begin
            st <= S_RD2;
          end
        end
        S_RD2: if (mem_req_ready) st <= S_WT2;
        S_WT2: if (mem_rsp_valid) begin
          frame_q <= ent_pn;
          wen_q   <= ent_w;
          if (!ent_v)              fault_q <= F_NP;
          else if (wr_q && !ent_w) fault_q <= F_PROT;
          else                     fault_q <= F_OK;
          st <= S_DONE;
        end
        S_DONE: begin
          fault_q <= F_OK;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic        req_write,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        res_valid,
  input logic [1:0]  res_fault,
  input logic [31:0] res_paddr
);
  logic [11:0] off_q;
  logic        wr_q;
  logic        busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        off_q  <= req_vaddr[11:0];
        wr_q   <= req_write;
        busy_q <= 1'b1;
      end else if (res_valid) begin
        busy_q <= 1'b0;
      end
    end
  end

  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !res_valid |-> !req_ready);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r10_result_owned: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy_q);

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 |-> res_paddr[11:0] == off_q);

  a_r6_fault_no_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 2'd0 |-> res_paddr == 32'd0);

  a_r8_prot_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd2 |-> wr_q);
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ptbr = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic        req_write = 0;
  logic        mem_req_valid;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        res_valid;
  logic [1:0]  res_fault;
  logic [31:0] res_paddr;
  logic        res_writable;

  int errors = 0, checks = 0, cycles = 0;
  int nrd;
  logic [31:0] rd_addr [2];
  bit mem_busy = 0;
  int mem_cnt;
  logic [31:0] mem_addr;

  always #5 clk = ~clk;

  pt_walker uut (.*);

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return {h[31:12], 10'h0, h[4], h[2] | h[3]};
  endfunction

  task automatic expect_walk(input logic [31:0] va, input logic wr, input logic [31:0] pb,
      output logic [1:0] f, output logic [31:0] pa, output logic w, output int n,
      output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] e1, e2;
    a1 = {pb[31:12], va[31:22], 2'b00};
    e1 = mem_fn(a1);
    a2 = {e1[31:12], va[21:12], 2'b00};
    pa = 0; w = 0;
    if (!e1[0]) begin f = 1; n = 1; return; end
    n = 2;
    e2 = mem_fn(a2);
    if (!e2[0]) f = 1;
    else if (wr && !e2[1]) f = 2;
    else begin f = 0; pa = {e2[31:12], va[11:0]}; w = e2[1]; end
  endtask

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (mem_busy) begin
        if (mem_cnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = mem_fn(mem_addr);
          mem_busy = 0;
        end else mem_cnt--;
      end
      mem_req_ready = !mem_busy && ($urandom % 3 != 0);
      if (mem_req_valid && mem_req_ready) begin
        mem_busy = 1;
        mem_addr = mem_req_addr;
        mem_cnt = $urandom % 5;
        if (nrd < 2) rd_addr[nrd] = mem_req_addr;
        nrd++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic do_walk(input logic [31:0] va, input logic wr, input logic [31:0] pb,
                         input bit noisy);
    logic [1:0] f; logic [31:0] pa, a1, a2; logic w; int n; int t;
    expect_walk(va, wr, pb, f, pa, w, n, a1, a2);
    @(negedge clk);
    ptbr = pb; nrd = 0;
    req_valid = 1; req_vaddr = va; req_write = wr;
    check("R9 idle ready", req_ready, 1);
    @(negedge clk);
    if (noisy) begin req_vaddr = ~va; req_write = ~wr; end
    else req_valid = 0;
    check("R9 busy not ready", req_ready, 0);
    t = 0;
    while (!res_valid && t < 300) begin @(negedge clk); t++; end
    if (!res_valid) begin
      errors++; checks++;
      $display("FAIL R10 no result actual=0 expected=1");
      req_valid = 0;
      return;
    end
    req_valid = 0;
    check("R6 R7 R8 fault code", res_fault, f);
    check("R4 paddr", res_paddr, pa);
    check("R4 writable", res_writable, w);
    check("R6 read count", nrd, n);
    check("R2 root address", rd_addr[0], a1);
    if (n == 2) check("R3 leaf address", rd_addr[1], a2);
    @(negedge clk);
    check("R10 one-cycle result", res_valid, 0);
  endtask

  task automatic find_va(input logic [1:0] want_f, input logic wr, input int want_n,
                         input logic [31:0] pb, output logic [31:0] va);
    logic [1:0] f; logic [31:0] pa, a1, a2; logic w; int n;
    for (int k = 0; k < 10000; k++) begin
      va = $urandom;
      expect_walk(va, wr, pb, f, pa, w, n, a1, a2);
      if (f == want_f && n == want_n) return;
    end
  endtask

  initial begin
    logic [31:0] va, pb;
    void'($urandom(32'h5eed1234));
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset req_ready", req_ready, 1);
    check("R1 reset mem_req_valid", mem_req_valid, 0);
    check("R1 reset res_valid", res_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 post-reset mem_req_valid", mem_req_valid, 0);

    pb = 32'h0004_0ABC;
    find_va(2'd1, 1'b0, 1, pb, va); do_walk(va, 0, pb, 0);   // R6
    find_va(2'd1, 1'b1, 2, pb, va); do_walk(va, 1, pb, 1);   // R7
    find_va(2'd2, 1'b1, 2, pb, va); do_walk(va, 1, pb, 0);   // R8 protection
    do_walk(va, 0, pb, 0);                                   // R8 read allowed
    find_va(2'd0, 1'b1, 2, pb, va); do_walk(va, 1, pb, 1);   // R4 write ok
    do_walk(va, 0, {pb[31:12], 12'hFFF}, 0);                 // R2 low base bits ignored

    for (int i = 0; i < 400; i++) begin
      pb = $urandom;
      do_walk($urandom, 1'($urandom), pb, bit'($urandom % 4 == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule